// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Detector

This block watches three 8-bit groups of general-purpose input pins, called A, B and F, and turns activity on them into interrupt requests. Each pin can be set up separately to sense a level (high or low) or an edge (rising or falling). Edge events are held in a sticky latch until software acknowledges them by writing a one to an end-of-interrupt register. A per-pin enable decides whether the pin can raise an interrupt at all. Before any detection, each pin passes through a two-flop synchroniser.

Software sees the block through a byte-wide register port. Each group has one mode byte, one polarity byte, one acknowledge byte, one enable byte and one status byte. In each of these bytes, bit i belongs to pin i. Groups A and B feed one shared interrupt line. Group F drives one interrupt line per pin, for use where each pin is routed to its own vector.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every mode, polarity, enable and latch bit is 0. Both interrupt outputs are low, and every register reads 0.
- R2: Each pin passes through two synchronising flops, giving the sampled level. An edge is detected by comparing the sampled level with its value one cycle earlier.
- R3: When a pin's mode bit is 0, the pin is level-sensed. It is pending while its sampled level equals its polarity bit (1 = high, 0 = low). Acknowledge writes do not affect it.
- R4: When a pin's mode bit is 1, the pin is edge-sensed. Polarity bit 1 selects a rising edge and 0 selects a falling edge. A detected edge sets the pin's latch, and the latch stays set until it is acknowledged.
- R5: Writing the acknowledge byte clears the latch of every pin whose bit is 1. Bits written as 0 leave their latches unchanged.
- R6: A pin whose enable bit is 0 is never pending, and an edge that is detected while its enable bit is 0 is not latched.
- R7: The status byte of a group reads back the pending state of each pin of that group.
- R8: `irq_ab_o` is high exactly when any pin of group A or group B is pending.
- R9: `irq_f_o[i]` is high exactly when pin i of group F is pending.
- R10: When an edge is detected on a pin in the same cycle that an acknowledge write targets that pin, the latch ends up set.
- R11: The register addresses are as follows:
  - Group A: mode 0x90, polarity 0x94, acknowledge 0x98, enable 0x9C, status 0xA0.
  - Group B: mode 0xAC, polarity 0xB0, acknowledge 0xB4, enable 0xB8, status 0xBC.
  - Group F: mode 0x4C, polarity 0x50, acknowledge 0x54, enable 0x58, status 0x5C.
  - Mode, polarity and enable bytes read back the last value written to them.
  - Acknowledge bytes and unmapped addresses read 0.
  - Writes to status bytes and unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_a_i | input | 8 | Group A pins, asynchronous |
| pin_b_i | input | 8 | Group B pins, asynchronous |
| pin_f_i | input | 8 | Group F pins, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_ab_o | output | 1 | Shared interrupt for groups A and B |
| irq_f_o | output | 8 | Per-pin interrupts for group F |

## Verification
The bench builds the block with its defaults: eight pins per group and two synchroniser stages. With two stages, the reference model can track the exact cycle in which each pin change reaches the status bytes and the interrupt outputs.

With eight pins, each group has both nibbles available. The bench can therefore put rising and falling edges, high and low levels, and enabled and disabled pins into one group at the same moment. It also slides an acknowledge write across the cycles around a detected edge, so that the collision case is reached at a known point.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NUM_GROUPS = 3;
  localparam int unsigned ADDR_W     = 8;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t mode;
    addr_t pol;
    addr_t ack;
    addr_t en;
    addr_t stat;
  } group_map_t;

  // group 0 = A, 1 = B, 2 = F
  function automatic group_map_t group_map(input int unsigned idx);
    group_map_t m;
    case (idx)
      0:       m = '{mode: 8'h90, pol: 8'h94, ack: 8'h98, en: 8'h9C, stat: 8'hA0};
      1:       m = '{mode: 8'hAC, pol: 8'hB0, ack: 8'hB4, en: 8'hB8, stat: 8'hBC};
      default: m = '{mode: 8'h4C, pol: 8'h50, ack: 8'h54, en: 8'h58, stat: 8'h5C};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter group_map_t  MAP         = group_map(0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  pin_i,
  input  logic              wr_en_i,
  input  addr_t             addr_i,
  input  logic [LINES-1:0]  wdata_i,
  output logic [LINES-1:0]  rdata_o,
  output logic [LINES-1:0]  pend_o
);
  logic [LINES-1:0] lvl, prev_q;
  logic [LINES-1:0] mode_q, pol_q, en_q, lat_q, lat_d;
  logic [LINES-1:0] edge_hit, ack;

  gpio_irq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  assign edge_hit = (pol_q & lvl & ~prev_q) | (~pol_q & ~lvl & prev_q);
  assign ack      = (wr_en_i && addr_i == MAP.ack) ? wdata_i : '0;
  // set beats clear on collision
  assign lat_d    = (lat_q & ~ack) | (en_q & mode_q & edge_hit);
  assign pend_o   = en_q & ((mode_q & lat_q) | (~mode_q & ~(lvl ^ pol_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      lat_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= lvl;
      lat_q  <= lat_d;
      if (wr_en_i && addr_i == MAP.mode) mode_q <= wdata_i;
      if (wr_en_i && addr_i == MAP.pol)  pol_q  <= wdata_i;
      if (wr_en_i && addr_i == MAP.en)   en_q   <= wdata_i;
    end
  end

  always_comb begin
    if      (addr_i == MAP.mode) rdata_o = mode_q;
    else if (addr_i == MAP.pol)  rdata_o = pol_q;
    else if (addr_i == MAP.en)   rdata_o = en_q;
    else if (addr_i == MAP.stat) rdata_o = pend_o;
    else                         rdata_o = '0;
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~lat_q & $past(lat_q & ~ack)) == '0));
  p_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_q & $past(ack & ~edge_hit)) == '0));
  p_dis_no_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_q & $past(~en_q & ~lat_q)) == '0));
  p_edge_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~lat_q & $past(en_q & mode_q & edge_hit & ack)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] pin_a_i,
  input  logic [LINES-1:0] pin_b_i,
  input  logic [LINES-1:0] pin_f_i,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] rdata_o,
  output logic             irq_ab_o,
  output logic [LINES-1:0] irq_f_o
);
  logic [NUM_GROUPS-1:0][LINES-1:0] pins, rd, pend;

  assign pins = {pin_f_i, pin_b_i, pin_a_i};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gpio_irq_group #(
      .LINES      (LINES),
      .SYNC_STAGES(SYNC_STAGES),
      .MAP        (group_map(g))
    ) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .wr_en_i(wr_en_i),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .rdata_o(rd[g]),
      .pend_o (pend[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) rdata_o |= rd[g];
  end

  assign irq_ab_o = |{pend[1], pend[0]};
  assign irq_f_o  = pend[2];

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_ab_o && irq_f_o == '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pa = 0, pb = 0, pf = 0;
  logic       wr = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata, irq_f;
  logic       irq_ab;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pa), .pin_b_i(pb), .pin_f_i(pf),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_ab_o(irq_ab), .irq_f_o(irq_f)
  );

  // reference model
  logic [7:0] m_mode[3], m_pol[3], m_en[3], m_lat[3], m_s1[3], m_s2[3], m_prev[3];

  function automatic logic [7:0] bmap(int g, int k); // k: 0 mode 1 pol 2 ack 3 en 4 stat
    logic [7:0] base;
    base = (g == 0) ? 8'h90 : (g == 1) ? 8'hAC : 8'h4C;
    return base + 8'(4 * k);
  endfunction

  function automatic logic [7:0] m_pend(int g);
    return m_en[g] & ((m_mode[g] & m_lat[g]) | (~m_mode[g] & ~(m_s2[g] ^ m_pol[g])));
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    for (int g = 0; g < 3; g++) begin
      if (a == bmap(g, 0)) return m_mode[g];
      if (a == bmap(g, 1)) return m_pol[g];
      if (a == bmap(g, 3)) return m_en[g];
      if (a == bmap(g, 4)) return m_pend(g);
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin
        m_mode[g] = 0; m_pol[g] = 0; m_en[g] = 0; m_lat[g] = 0;
        m_s1[g] = 0; m_s2[g] = 0; m_prev[g] = 0;
      end
    end else begin
      for (int g = 0; g < 3; g++) begin
        logic [7:0] hit, ackb, pin;
        hit  = 0;
        for (int i = 0; i < 8; i++) begin
          if (m_pol[g][i]) hit[i] = m_s2[g][i] && !m_prev[g][i];
          else             hit[i] = !m_s2[g][i] && m_prev[g][i];
        end
        ackb = (wr && addr == bmap(g, 2)) ? wdata : 8'h00;
        m_lat[g] = (m_lat[g] & ~ackb) | (m_en[g] & m_mode[g] & hit);
        if (wr && addr == bmap(g, 0)) m_mode[g] = wdata;
        if (wr && addr == bmap(g, 1)) m_pol[g]  = wdata;
        if (wr && addr == bmap(g, 3)) m_en[g]   = wdata;
        pin = (g == 0) ? pa : (g == 1) ? pb : pf;
        m_prev[g] = m_s2[g];
        m_s2[g]   = m_s1[g];
        m_s1[g]   = pin;
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R8", {7'd0, irq_ab}, {7'd0, (m_pend(0) != 0) || (m_pend(1) != 0)});
    check("R9", irq_f, m_pend(2));
    check(cur_req, rdata, m_read(addr));
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wreg(logic [7:0] a, logic [7:0] d, logic [7:0] rd_a);
    wr = 1; addr = a; wdata = d;
    step(1);
    wr = 0; addr = rd_a;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1: every register reads 0 after reset
    cur_req = "R1";
    for (int a = 0; a < 256; a += 4) begin addr = 8'(a); step(1); end

    // R3: level sensing on group A, high on low nibble, low on high nibble
    cur_req = "R3";
    wreg(8'h90, 8'h00, 8'hA0);
    wreg(8'h94, 8'h0F, 8'hA0);
    wreg(8'h9C, 8'hFF, 8'hA0);
    pa = 8'h05; step(4);
    pa = 8'hF0; step(4);
    wreg(8'h98, 8'hFF, 8'hA0); step(2); // ack must not clear level
    pa = 8'h0F; step(4);

    // R4: edge sensing on group B, low nibble rising, high nibble falling
    cur_req = "R4";
    wreg(8'hAC, 8'hFF, 8'hBC);
    wreg(8'hB0, 8'h0F, 8'hBC);
    wreg(8'hB8, 8'hFF, 8'hBC);
    pb = 8'hFF; step(5);
    pb = 8'h00; step(5);
    pb = 8'h11; step(2); pb = 8'h00; step(5);

    // R5: partial ack leaves other latches set
    cur_req = "R5";
    wreg(8'hB4, 8'h05, 8'hBC); step(2);
    wreg(8'hB4, 8'h00, 8'hBC); step(2);
    wreg(8'hB4, 8'hFF, 8'hBC); step(2);

    // R6: edges on group F while disabled are dropped
    cur_req = "R6";
    wreg(8'h4C, 8'hFF, 8'h5C);
    wreg(8'h50, 8'hFF, 8'h5C);
    pf = 8'hFF; step(5);
    wreg(8'h58, 8'hFF, 8'h5C); step(3);
    pf = 8'h00; step(4);

    // R9: per-pin routing of group F
    cur_req = "R9";
    for (int i = 0; i < 8; i++) begin
      pf = 8'(1 << i); step(5);
      pf = 8'h00; step(2);
      wreg(8'h54, 8'(1 << i), 8'h5C); step(1);
    end

    // R10: slide ack across the cycle an edge is detected
    cur_req = "R10";
    for (int d = 0; d < 6; d++) begin
      wreg(8'h54, 8'hFF, 8'h5C);
      pf = 8'h01; step(d);
      wreg(8'h54, 8'h01, 8'h5C); step(4);
      pf = 8'h00; step(3);
    end

    // R7/R8: status bytes and shared line across A and B
    cur_req = "R7";
    wreg(8'h9C, 8'h00, 8'hA0); step(3);
    wreg(8'hB4, 8'hFF, 8'hBC); step(2);
    pb = 8'h01; step(5); addr = 8'hBC; step(2);

    // R11: unmapped and status writes change nothing
    cur_req = "R11";
    wreg(8'h00, 8'hFF, 8'h90);
    wreg(8'hA0, 8'hFF, 8'h9C);
    wreg(8'hFC, 8'hFF, 8'h58);
    for (int g = 0; g < 3; g++)
      for (int k = 0; k < 5; k++) begin addr = bmap(g, k); step(1); end

    // R2: random traffic against the cycle-exact model
    cur_req = "R2";
    for (int c = 0; c < 4000; c++) begin
      pa = 8'($urandom); pb = 8'($urandom); pf = 8'($urandom);
      if (($urandom % 4) == 0) begin
        int g, k;
        g = int'($urandom % 3); k = int'($urandom % 5);
        wr = 1; addr = bmap(g, k); wdata = 8'($urandom);
      end else begin
        wr = 0; addr = bmap(int'($urandom % 3), int'($urandom % 5));
      end
      step(1 + int'($urandom % 3));
    end
    wr = 0;
    step(2);
    finish_run();
  end
endmodule